// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block sits between a processor core and the external memory and I/O bus. It turns a single transfer request from the core into one external bus cycle with four phases, T1 to T4. A held address bus carries the full address for the whole cycle. A shared address/data bus carries the low address bits in T1 and write data after that, or is released for a read. The controller also drives a latch pulse for the address, read and write strobes, byte write enables and a memory-or-I/O indicator.

The core raises `req_valid` with the address, direction, high-byte enable, space select and write data, and holds them until `req_ack` pulses. Read data is returned on `rd_data` in the same cycle as the acknowledge. The `rdy` input stretches a cycle by repeating T3. A strap input, `bus8_mode`, selects an 8-bit external data path. In that mode the two byte write enables are replaced by one write-byte strobe, and data is steered onto the low byte lane.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: A request seen in idle is accepted at that clock edge. The phases then run T1, T2, T3 (repeated while waiting), T4, one clock each, so a cycle with no wait states takes 4 clocks from acceptance to the acknowledge.
- R2: `a_out` holds the accepted address and `mio` holds the space (1 = memory, 0 = I/O) unchanged from T1 through T4.
- R3: `ale` is high in T1 only. In T1, `ad_oe` is 1 and `ad_out` equals the low 16 address bits.
- R4: For a read, `rd_n` is low in T2 and in every T3, and `ad_oe` is 0 after T1. In 16-bit mode `rd_data` takes `ad_in` as sampled at the end of the last T3, and keeps that value until the next read completes.
- R5: For a write, `wr_n` is low in T2 and in every T3. `rd_n` stays high. `ad_oe` is 1 from T2 through T4, and `ad_out` carries the write data throughout.
- R6: In 16-bit mode, `whb_n` = `req_bhe_n` OR `wr_n` and `wlb_n` = address bit 0 OR `wr_n`, while `wb_n` stays 1.
- R7: In 8-bit mode, `wb_n` follows `wr_n` and `whb_n` and `wlb_n` stay 1. The write byte on `ad_out[7:0]` is data bits 15:8 when address bit 0 is 1 and bits 7:0 otherwise, with `ad_out[15:8]` = 0. A read returns {8'h00, `ad_in[7:0]`}.
- R8: If `rdy` is low at the end of a T3, another T3 follows with the strobe still asserted. T4 follows the first T3 that ends with `rdy` high.
- R9: `req_ack` is a single-clock pulse in T4. After T4 the controller returns to idle, where `rd_n`, `wr_n`, `whb_n`, `wlb_n` and `wb_n` are 1, and `ale`, `ad_oe` and `req_ack` are 0.
- R10: While reset is applied, the outputs take the idle values of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus8_mode | input | 1 | Strap: 1 selects the 8-bit external data bus |
| req_valid | input | 1 | Core transfer request, held until acknowledged |
| req_addr | input | 20 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bhe_n | input | 1 | Active-low byte-high enable |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | Transfer complete pulse (T4) |
| rd_data | output | 16 | Read data returned to the core |
| rdy | input | 1 | External ready, sampled at the end of T3 |
| a_out | output | 20 | Held address bus |
| ad_out | output | 16 | Multiplexed address/data bus, output value |
| ad_oe | output | 1 | Multiplexed bus output enable |
| ad_in | input | 16 | Multiplexed bus, input value |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| whb_n | output | 1 | Active-low high-byte write enable |
| wlb_n | output | 1 | Active-low low-byte write enable |
| wb_n | output | 1 | Active-low write-byte strobe (8-bit mode) |
| mio | output | 1 | Memory (1) or I/O (0) indicator |

## Verification
The bench raises a request on a falling edge, so T1 outputs are due one rising edge later and T2 one edge after that. T4 comes at edge 4 plus the number of wait states, and idle follows one edge after T4. The driver steps through these phases on successive falling edges and compares every phase output there, half a clock away from the edge that changed it. A scoreboard counts the rising edges on which the request was held. When the acknowledge appears, it expects the count to equal 4 plus the waits and `rd_data` to equal the queued value. Before the last T3 ends, `rdy` is driven low once for each requested wait state.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4
  } phase_e;
endpackage

// File: rtl/mbus_phase_fsm.sv
module mbus_phase_fsm
  import mbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   rdy,
  output phase_e phase,
  output logic   accept,
  output logic   last_t3
);
  phase_e phase_nx;

  always_comb begin
    phase_nx = phase;
    accept   = 1'b0;
    last_t3  = 1'b0;
    case (phase)
      PH_IDLE: if (req_valid) begin
                 phase_nx = PH_T1;
                 accept   = 1'b1;
               end
      PH_T1:   phase_nx = PH_T2;
      PH_T2:   phase_nx = PH_T3;
      PH_T3:   if (rdy) begin
                 phase_nx = PH_T4;
                 last_t3  = 1'b1;
               end
      PH_T4:   phase_nx = PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end

  AST_T1_TO_T2:   assert property (@(posedge clk) disable iff (!rst_n)
                    phase == PH_T1 |=> phase == PH_T2); // R1
  AST_T2_TO_T3:   assert property (@(posedge clk) disable iff (!rst_n)
                    phase == PH_T2 |=> phase == PH_T3); // R1
  AST_T3_TO_T4:   assert property (@(posedge clk) disable iff (!rst_n)
                    (phase == PH_T3 && rdy) |=> phase == PH_T4); // R1
  AST_WAIT_STAY:  assert property (@(posedge clk) disable iff (!rst_n)
                    (phase == PH_T3 && !rdy) |=> phase == PH_T3); // R8
  AST_T4_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                    phase == PH_T4 |=> phase == PH_IDLE); // R9
endmodule

// File: rtl/mbus_req_hold.sv
module mbus_req_hold #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          last_t3,
  input  logic          bus8_mode,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_bhe_n,
  input  logic          req_mem,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] ad_in,
  output logic [AW-1:0] addr_q,
  output logic          write_q,
  output logic          bhe_n_q,
  output logic          mem_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rd_data
);
  localparam int BW = DW / 2;

  logic          rd_cap_en;
  logic [DW-1:0] rd_nx;

  assign rd_cap_en = last_t3 & ~write_q;
  assign rd_nx     = bus8_mode ? {{(DW-BW){1'b0}}, ad_in[BW-1:0]} : ad_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      bhe_n_q <= 1'b1;
      mem_q   <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      write_q <= req_write;
      bhe_n_q <= req_bhe_n;
      mem_q   <= req_mem;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_data <= '0;
    else if (rd_cap_en) rd_data <= rd_nx;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                 !rd_cap_en |=> $stable(rd_data)); // R4
endmodule

// File: rtl/mbus_bus_drive.sv
module mbus_bus_drive
  import mbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  logic          bus8_mode,
  input  logic [AW-1:0] addr_q,
  input  logic          write_q,
  input  logic          bhe_n_q,
  input  logic          mem_q,
  input  logic [DW-1:0] wdata_q,
  output logic [AW-1:0] a_out,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          whb_n,
  output logic          wlb_n,
  output logic          wb_n,
  output logic          mio,
  output logic          req_ack
);
  localparam int BW = DW / 2;

  logic          strobe_ph;
  logic          data_ph;
  logic [BW-1:0] byte_sel;
  logic [DW-1:0] wr_lanes;

  assign strobe_ph = (phase == PH_T2) || (phase == PH_T3);
  assign data_ph   = strobe_ph || (phase == PH_T4);
  assign byte_sel  = addr_q[0] ? wdata_q[DW-1:DW-BW] : wdata_q[BW-1:0];

  generate
    if (DW > BW) begin : g_lanes
      assign wr_lanes = bus8_mode ? {{(DW-BW){1'b0}}, byte_sel} : wdata_q;
    end else begin : g_single
      assign wr_lanes = wdata_q;
    end
  endgenerate

  always_comb begin
    a_out   = addr_q;
    mio     = mem_q;
    ale     = (phase == PH_T1);
    req_ack = (phase == PH_T4);
    rd_n    = ~(strobe_ph & ~write_q);
    wr_n    = ~(strobe_ph & write_q);
    if (bus8_mode) begin
      whb_n = 1'b1;
      wlb_n = 1'b1;
      wb_n  = wr_n;
    end else begin
      whb_n = bhe_n_q | wr_n;
      wlb_n = addr_q[0] | wr_n;
      wb_n  = 1'b1;
    end
    if (phase == PH_T1) begin
      ad_oe  = 1'b1;
      ad_out = addr_q[DW-1:0];
    end else if (data_ph && write_q) begin
      ad_oe  = 1'b1;
      ad_out = wr_lanes;
    end else begin
      ad_oe  = 1'b0;
      ad_out = '0;
    end
  end

  AST_ADDR_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
                     data_ph |-> ($stable(a_out) && $stable(mio))); // R2
  AST_ALE_ADDR:    assert property (@(posedge clk) disable iff (!rst_n)
                     ale |-> (ad_oe && rd_n && wr_n)); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
                     !(!rd_n && !wr_n)); // R4
  AST_WHB_GATED:   assert property (@(posedge clk) disable iff (!rst_n)
                     (!whb_n || !wlb_n) |-> (!wr_n && !bus8_mode)); // R6
  AST_WB_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n)
                     !wb_n |-> (bus8_mode && whb_n && wlb_n && !wr_n)); // R7
  AST_ACK_PULSE:   assert property (@(posedge clk) disable iff (!rst_n)
                     req_ack |=> !req_ack); // R9
  AST_IDLE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n)
                     phase == PH_IDLE |-> (rd_n && wr_n && !ad_oe && !ale && !req_ack)); // R9
endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
  import mbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus8_mode,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_bhe_n,
  input  logic          req_mem,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ack,
  output logic [DW-1:0] rd_data,
  input  logic          rdy,
  output logic [AW-1:0] a_out,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          whb_n,
  output logic          wlb_n,
  output logic          wb_n,
  output logic          mio
);
  logic          rst_meta;
  logic          rst_sync_n;
  phase_e        phase;
  logic          accept;
  logic          last_t3;
  logic [AW-1:0] addr_q;
  logic          write_q;
  logic          bhe_n_q;
  logic          mem_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  mbus_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .rdy       (rdy),
    .phase     (phase),
    .accept    (accept),
    .last_t3   (last_t3)
  );

  mbus_req_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .last_t3   (last_t3),
    .bus8_mode (bus8_mode),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_bhe_n (req_bhe_n),
    .req_mem   (req_mem),
    .req_wdata (req_wdata),
    .ad_in     (ad_in),
    .addr_q    (addr_q),
    .write_q   (write_q),
    .bhe_n_q   (bhe_n_q),
    .mem_q     (mem_q),
    .wdata_q   (wdata_q),
    .rd_data   (rd_data)
  );

  mbus_bus_drive #(.AW(AW), .DW(DW)) u_drive (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .phase     (phase),
    .bus8_mode (bus8_mode),
    .addr_q    (addr_q),
    .write_q   (write_q),
    .bhe_n_q   (bhe_n_q),
    .mem_q     (mem_q),
    .wdata_q   (wdata_q),
    .a_out     (a_out),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .whb_n     (whb_n),
    .wlb_n     (wlb_n),
    .wb_n      (wb_n),
    .mio       (mio),
    .req_ack   (req_ack)
  );
endmodule

// File: tb/sim_mbus_cycle_ctrl.sv
`timescale 1ns/1ps
module sim_mbus_cycle_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus8_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_bhe_n = 1'b1;
  logic        req_mem = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        req_ack;
  logic [15:0] rd_data;
  logic        rdy = 1'b1;
  logic [19:0] a_out;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [15:0] ad_in = 16'h0000;
  logic        ale, rd_n, wr_n, whb_n, wlb_n, wb_n, mio;

  int checks = 0;
  int fails  = 0;
  logic [15:0] last_rd = 16'h0000;

  typedef struct { int cyc; logic [15:0] rd; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  mbus_cycle_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus8_mode(bus8_mode), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .req_bhe_n(req_bhe_n),
    .req_mem(req_mem), .req_wdata(req_wdata), .req_ack(req_ack),
    .rd_data(rd_data), .rdy(rdy), .a_out(a_out), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .whb_n(whb_n), .wlb_n(wlb_n), .wb_n(wb_n), .mio(mio)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(rd_n && wr_n && whb_n && wlb_n && wb_n, {tag, " strobes high"},
        {27'd0, rd_n, wr_n, whb_n, wlb_n, wb_n}, 32'h1f);
    chk(!ale && !ad_oe && !req_ack, {tag, " ale/oe/ack low"},
        {29'd0, ale, ad_oe, req_ack}, 32'h0);
  endtask

  task automatic chk_strobes(input bit wr, input logic [19:0] addr, input bit bhe_n,
                             input string ph);
    if (wr) begin
      chk(!wr_n && rd_n, {"R5 wr strobe ", ph}, {30'd0, wr_n, rd_n}, 32'h1);
      if (bus8_mode)
        chk(!wb_n && whb_n && wlb_n, {"R7 byte strobes ", ph},
            {29'd0, whb_n, wlb_n, wb_n}, 32'h6);
      else
        chk(whb_n == bhe_n && wlb_n == addr[0] && wb_n, {"R6 byte enables ", ph},
            {29'd0, whb_n, wlb_n, wb_n}, {29'd0, bhe_n, addr[0], 1'b1});
    end else begin
      chk(!rd_n && wr_n, {"R4 rd strobe ", ph}, {30'd0, rd_n, wr_n}, 32'h1);
      chk(!ad_oe, {"R4 ad released ", ph}, {31'd0, ad_oe}, 32'h0);
      chk(whb_n && wlb_n && wb_n, {"R6 no byte enables on read ", ph},
          {29'd0, whb_n, wlb_n, wb_n}, 32'h7);
    end
  endtask

  task automatic xfer(input logic [19:0] addr, input bit wr, input bit bhe_n,
                      input bit mem, input logic [15:0] wd, input int waits,
                      input logic [15:0] rdv);
    logic [15:0] exp_ad;
    int rem;
    exp_t e;
    exp_ad = bus8_mode ? {8'h00, (addr[0] ? wd[15:8] : wd[7:0])} : wd;
    if (!wr) last_rd = bus8_mode ? {8'h00, rdv[7:0]} : rdv;
    e.cyc = 4 + waits;
    e.rd  = last_rd;
    exp_q.push_back(e);
    req_addr = addr; req_write = wr; req_bhe_n = bhe_n; req_mem = mem;
    req_wdata = wd; req_valid = 1'b1; rdy = 1'b1; ad_in = 16'h5a5a;
    @(negedge clk); // T1
    chk(ale == 1'b1, "R3 ale in T1", {31'd0, ale}, 32'h1);
    chk(ad_oe && ad_out == addr[15:0], "R3 address on ad in T1",
        {15'd0, ad_oe, ad_out}, {15'd0, 1'b1, addr[15:0]});
    chk(a_out == addr && mio == mem, "R2 address/space in T1",
        {11'd0, mio, a_out}, {11'd0, mem, addr});
    chk(rd_n && wr_n, "R1 no strobe in T1", {30'd0, rd_n, wr_n}, 32'h3);
    @(negedge clk); // T2
    chk(!ale, "R3 ale low after T1", {31'd0, ale}, 32'h0);
    chk_strobes(wr, addr, bhe_n, "T2");
    if (wr) chk(ad_oe && ad_out == exp_ad, bus8_mode ? "R7 lane data T2" : "R5 data T2",
                {15'd0, ad_oe, ad_out}, {15'd0, 1'b1, exp_ad});
    ad_in = rdv;
    rem = waits;
    forever begin
      @(negedge clk); // T3
      chk_strobes(wr, addr, bhe_n, rem < waits ? "R8 wait T3" : "T3");
      chk(a_out == addr && mio == mem, "R2 address/space held in T3",
          {11'd0, mio, a_out}, {11'd0, mem, addr});
      chk(!req_ack, "R8 no ack during T3", {31'd0, req_ack}, 32'h0);
      if (rem == 0) begin rdy = 1'b1; break; end
      rdy = 1'b0;
      rem--;
    end
    @(negedge clk); // T4
    chk(rd_n && wr_n, "R9 strobes off in T4", {30'd0, rd_n, wr_n}, 32'h3);
    chk(a_out == addr && mio == mem, "R2 address/space held in T4",
        {11'd0, mio, a_out}, {11'd0, mem, addr});
    if (wr) chk(ad_oe && ad_out == exp_ad, "R5 data held in T4",
                {15'd0, ad_oe, ad_out}, {15'd0, 1'b1, exp_ad});
    else    chk(!ad_oe, "R4 ad released in T4", {31'd0, ad_oe}, 32'h0);
    req_valid = 1'b0;
    @(negedge clk); // idle
    ad_in = 16'hc3c3;
    chk_idle("R9 idle after T4");
    chk(rd_data == last_rd, "R4 rd_data held in idle", {16'd0, rd_data}, {16'd0, last_rd});
  endtask

  // Scoreboard monitor: counts held-request edges, compares on acknowledge.
  initial begin
    int cnt = 0;
    exp_t e;
    forever begin
      @(posedge clk);
      if (req_valid) cnt++;
      @(negedge clk);
      #1;
      if (req_ack) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected ack", 32'h1, 32'h0);
        end else begin
          e = exp_q.pop_front();
          chk(cnt == e.cyc, "R1 cycle length to ack", cnt, e.cyc);
          chk(rd_data == e.rd, bus8_mode ? "R7 read data with ack" : "R4 read data with ack",
              {16'd0, rd_data}, {16'd0, e.rd});
        end
        cnt = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R10 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle("R10 after reset release");
    // 16-bit read, memory, no wait
    xfer(20'h12344, 1'b0, 1'b0, 1'b1, 16'h0000, 0, 16'hbeef);
    // 16-bit word write, I/O, two waits
    xfer(20'ha5a50, 1'b1, 1'b0, 1'b0, 16'h1357, 2, 16'h0000);
    // high byte only write (odd address)
    xfer(20'h00101, 1'b1, 1'b0, 1'b1, 16'h9a00, 0, 16'h0000);
    // low byte only write (even address, high byte disabled)
    xfer(20'h00202, 1'b1, 1'b1, 1'b1, 16'h0042, 1, 16'h0000);
    // read with three waits, I/O space
    xfer(20'hfff0e, 1'b0, 1'b0, 1'b0, 16'h0000, 3, 16'h6b2d);
    // 8-bit bus mode
    bus8_mode = 1'b1;
    @(negedge clk);
    xfer(20'h30001, 1'b1, 1'b1, 1'b1, 16'habcd, 0, 16'h0000);
    xfer(20'h30002, 1'b1, 1'b1, 1'b0, 16'habcd, 1, 16'h0000);
    xfer(20'h40005, 1'b0, 1'b1, 1'b1, 16'h0000, 2, 16'h7799);
    bus8_mode = 1'b0;
    @(negedge clk);
    xfer(20'h7654e, 1'b0, 1'b0, 1'b1, 16'h0000, 0, 16'h2468);
    repeat (3) @(negedge clk);
    chk_idle("R9 quiet at end");
    chk(exp_q.size() == 0, "R9 all acks seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule